// File: doc/BRIEF.md
# ADC Result Formatting Register

This block sits between a differential converter core and a CPU's register file. The core hands over a signed difference code. The block turns that code into a 16-bit result and shows it to software as a high byte and a low byte. When a conversion-complete strobe arrives, the block reduces the raw difference to a result code and holds it. The code is built according to the conversion mode in force at that moment.

Two conversion modes exist. Unipolar mode is the default and gives a one-sided 10-bit code. A difference outside that range, including any negative difference, is pinned to full scale. Bipolar mode gives a two's-complement code with a sign bit and nine magnitude bits, clipped to the signed range.

An alignment select places the held code. Right alignment puts it at the bottom of the register; left alignment puts it at the top. The two bytes are a combinational view of the held code, so flipping the alignment select reformats the result at once, with no new conversion.

Top module: `adc_result_fmt`

## Requirements
- R1: While reset is active, and after reset before any strobe, data_hi and data_lo both read 0x00, whatever the alignment select.
- R2: In unipolar mode (bipolar_sel=0), a strobe with a raw difference from 0 to 1023 holds that value as the 10-bit code.
- R3: In unipolar mode, a strobe with a negative raw difference holds the full-scale code 0x3FF.
- R4: In unipolar mode, a strobe with a raw difference above 1023 holds the full-scale code 0x3FF.
- R5: In bipolar mode (bipolar_sel=1), a strobe with a raw difference from -512 to 511 holds its 10-bit two's-complement form; bit 9 of the code is the sign.
- R6: In bipolar mode, a raw difference above 511 holds 0x1FF and one below -512 holds 0x200.
- R7: With right alignment (left_adj=0), the code occupies bits 9:0 of {data_hi,data_lo}. Bits 15:10 copy the code's sign bit for a code held in bipolar mode, and read zero for a code held in unipolar mode.
- R8: With left alignment (left_adj=1), the code occupies bits 15:6 of {data_hi,data_lo}, and bits 5:0 read zero.
- R9: A change of left_adj changes data_hi and data_lo in the same cycle, with no strobe and no clock edge needed.
- R10: Without a strobe, changes on raw_diff and bipolar_sel leave data_hi and data_lo unchanged.
- R11: The mode used for saturation and sign extension is the one sampled on the strobe, not the current bipolar_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_diff | input | RAW_W (12) | Signed difference code from the converter core |
| conv_done | input | 1 | One-cycle strobe: conversion complete, capture raw_diff |
| bipolar_sel | input | 1 | 0 unipolar, 1 bipolar; sampled on the strobe |
| left_adj | input | 1 | 1 left aligned, 0 right aligned; acts live |
| data_hi | output | REG_W/2 (8) | Upper byte of the formatted result |
| data_lo | output | REG_W/2 (8) | Lower byte of the formatted result |

## Verification
The bench uses the default parameters: a 12-bit raw difference, a 10-bit code and a 16-bit register. Because the raw input is wider than the code, the bench can drive values past +1023, past +511 and below -512. That brings every saturation and clipping branch within reach, as well as the exact edges of each range. The 6-bit gap between code and register lets the zero padding under left alignment and the sign fill under right alignment be checked bit for bit. That gap also lets the bench show a live alignment flip between clock edges.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic {
    MODE_UNIPOLAR = 1'b0,
    MODE_BIPOLAR  = 1'b1
  } conv_mode_e;

  typedef enum logic {
    ALIGN_RIGHT = 1'b0,
    ALIGN_LEFT  = 1'b1
  } align_e;
endpackage

// File: rtl/adc_fmt_shaper.sv
module adc_fmt_shaper
  import adc_fmt_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int RES_W = 10
) (
  input  logic signed [RAW_W-1:0] raw_in,
  input  conv_mode_e              mode,
  output logic        [RES_W-1:0] code_out
);
  localparam int UNI_MAX = (1 << RES_W) - 1;
  localparam int BIP_MAX = (1 << (RES_W - 1)) - 1;
  localparam logic signed [RAW_W-1:0] UNI_TOP = RAW_W'(UNI_MAX);
  localparam logic signed [RAW_W-1:0] BIP_TOP = RAW_W'(BIP_MAX);
  localparam logic signed [RAW_W-1:0] BIP_BOT = ~BIP_TOP;

  // one-sided code: anything outside 0..UNI_MAX pins to full scale
  function automatic logic [RES_W-1:0] to_unipolar(input logic signed [RAW_W-1:0] v);
    if (v < 0 || v > UNI_TOP) return {RES_W{1'b1}};
    return v[RES_W-1:0];
  endfunction

  // two-sided code: clip to the signed range of RES_W bits
  function automatic logic [RES_W-1:0] to_bipolar(input logic signed [RAW_W-1:0] v);
    if (v > BIP_TOP) return {1'b0, {(RES_W-1){1'b1}}};
    if (v < BIP_BOT) return {1'b1, {(RES_W-1){1'b0}}};
    return v[RES_W-1:0];
  endfunction

  always_comb begin
    if (mode == MODE_BIPOLAR) code_out = to_bipolar(raw_in);
    else                      code_out = to_unipolar(raw_in);
  end
endmodule

// File: rtl/adc_fmt_hold.sv
module adc_fmt_hold
  import adc_fmt_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] code_d,
  input  conv_mode_e       mode_d,
  output logic [RES_W-1:0] code_q,
  output conv_mode_e       mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= MODE_UNIPOLAR;
    end else if (load) begin
      code_q <= code_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/adc_fmt_align.sv
module adc_fmt_align
  import adc_fmt_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int REG_W = 16
) (
  input  logic [RES_W-1:0] code,
  input  conv_mode_e       mode,
  input  align_e           align,
  output logic [REG_W-1:0] word
);
  localparam int PAD_W = REG_W - RES_W;

  function automatic logic [REG_W-1:0] place(input logic [RES_W-1:0] c,
                                             input logic fill, input align_e a);
    if (a == ALIGN_LEFT) return {c, {PAD_W{1'b0}}};
    return {{PAD_W{fill}}, c};
  endfunction

  logic sign_fill;
  assign sign_fill = (mode == MODE_BIPOLAR) && code[RES_W-1];
  assign word      = place(code, sign_fill, align);
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_fmt_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int RES_W = 10,
  parameter int REG_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [RAW_W-1:0] raw_diff,
  input  logic                    conv_done,
  input  logic                    bipolar_sel,
  input  logic                    left_adj,
  output logic [REG_W/2-1:0]      data_hi,
  output logic [REG_W/2-1:0]      data_lo
);
  localparam int HALF_W = REG_W / 2;
  localparam int PAD_W  = REG_W - RES_W;
  localparam logic signed [RAW_W-1:0] BIP_TOP_S = RAW_W'((1 << (RES_W - 1)) - 1);

  // named internal events for the assertions
  logic             load_evt;
  logic [RES_W-1:0] shaped_code;
  logic [RES_W-1:0] held_code;
  conv_mode_e       held_mode;
  logic [REG_W-1:0] view_word;

  assign load_evt = conv_done;

  adc_fmt_shaper #(.RAW_W(RAW_W), .RES_W(RES_W)) shaper_i (
    .raw_in  (raw_diff),
    .mode    (conv_mode_e'(bipolar_sel)),
    .code_out(shaped_code)
  );

  adc_fmt_hold #(.RES_W(RES_W)) hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .code_d(shaped_code),
    .mode_d(conv_mode_e'(bipolar_sel)),
    .code_q(held_code),
    .mode_q(held_mode)
  );

  adc_fmt_align #(.RES_W(RES_W), .REG_W(REG_W)) align_i (
    .code (held_code),
    .mode (held_mode),
    .align(align_e'(left_adj)),
    .word (view_word)
  );

  assign data_hi = view_word[REG_W-1:HALF_W];
  assign data_lo = view_word[HALF_W-1:0];

  assert_unipolar_neg_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !bipolar_sel && raw_diff[RAW_W-1]) |=> (held_code == {RES_W{1'b1}}));

  assert_bipolar_clip_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && bipolar_sel && (raw_diff > BIP_TOP_S)) |=> (held_code == {1'b0, {(RES_W-1){1'b1}}}));

  assert_sign_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_adj && held_mode == MODE_BIPOLAR) |->
      ({data_hi, data_lo} >> (RES_W - 1) == '0) ||
      ({data_hi, data_lo} >> (RES_W - 1) == REG_W'((1 << (PAD_W + 1)) - 1)));

  assert_left_zero_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    left_adj |-> (view_word[PAD_W-1:0] == '0));

  assert_hold_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt) |=> ((left_adj != $past(left_adj)) || $stable({data_hi, data_lo})));
endmodule

// File: tb/adc_result_fmt_tb_top.sv
module adc_result_fmt_tb_top;
  localparam int NV = 16;
  // {raw[11:0], bipolar, left, expected[15:0]}
  localparam logic [29:0] VEC [NV] = '{
    {12'h000, 1'b0, 1'b0, 16'h0000},  // R2 zero
    {12'h155, 1'b0, 1'b0, 16'h0155},  // R2
    {12'h3FF, 1'b0, 1'b0, 16'h03FF},  // R2 top edge
    {12'h400, 1'b0, 1'b0, 16'h03FF},  // R4 just over
    {12'hFFF, 1'b0, 1'b0, 16'h03FF},  // R3 -1
    {12'h800, 1'b0, 1'b1, 16'hFFC0},  // R3 most negative, R8
    {12'h2AB, 1'b0, 1'b1, 16'hAAC0},  // R8
    {12'h0C8, 1'b1, 1'b0, 16'h00C8},  // R5 +200
    {12'hF38, 1'b1, 1'b0, 16'hFF38},  // R5 -200, R7
    {12'h1FF, 1'b1, 1'b0, 16'h01FF},  // R5 top edge
    {12'h200, 1'b1, 1'b0, 16'h01FF},  // R6 +512
    {12'hE00, 1'b1, 1'b0, 16'hFE00},  // R5 bottom edge
    {12'hDFF, 1'b1, 1'b0, 16'hFE00},  // R6 -513
    {12'h7FF, 1'b1, 1'b1, 16'h7FC0},  // R6, R8
    {12'hF38, 1'b1, 1'b1, 16'hCE00},  // R8 negative left
    {12'h001, 1'b1, 1'b1, 16'h0040}   // R8
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [11:0] raw_diff = '0;
  logic               conv_done = 1'b0;
  logic               bipolar_sel = 1'b0;
  logic               left_adj = 1'b0;
  logic [7:0]         data_hi;
  logic [7:0]         data_lo;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  adc_result_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .raw_diff(raw_diff), .conv_done(conv_done),
    .bipolar_sel(bipolar_sel), .left_adj(left_adj),
    .data_hi(data_hi), .data_lo(data_lo)
  );

  function automatic string vec_req(input int i);
    case (i)
      0, 1, 2:        return "R2";
      3:              return "R4";
      4:              return "R3";
      5:              return "R3_R8";
      6, 14, 15:      return "R8";
      7, 9, 11:       return "R5";
      8:              return "R5_R7";
      10, 12:         return "R6";
      default:        return "R6_R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if ({data_hi, data_lo} !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, {data_hi, data_lo}, exp);
    end
  endtask

  task automatic convert(input logic [11:0] r, input logic b, input logic l);
    @(negedge clk);
    raw_diff = r; bipolar_sel = b; left_adj = l; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);
    left_adj = 1'b1; #1;
    check("R1", 16'h0000);
    left_adj = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      convert(VEC[i][29:18], VEC[i][17], VEC[i][16]);
      check(vec_req(i), VEC[i][15:0]);
    end

    // R9: live alignment flip between clock edges
    convert(12'h155, 1'b0, 1'b0);
    check("R9", 16'h0155);
    #0.5 left_adj = 1'b1; #0.5;
    check("R9", 16'h5540);
    left_adj = 1'b0; #0.5;
    check("R9", 16'h0155);

    // R10: no strobe, inputs move, output holds
    @(negedge clk);
    raw_diff = 12'hFFF; bipolar_sel = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", 16'h0155);

    // R11: mode captured on strobe
    convert(12'hF38, 1'b1, 1'b0);
    bipolar_sel = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", 16'hFF38);
    convert(12'hF38, 1'b0, 1'b0);
    check("R11", 16'h03FF);

    // R7: unipolar code with top bit set keeps high bits zero
    convert(12'h200, 1'b0, 1'b0);
    check("R7", 16'h0200);

    // R1: reset clears held result
    rst_n = 1'b0; #1;
    check("R1", 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule